// File: doc/BRIEF.md
# Register-Pair Double-Word Memory Sequencer

This block moves a 64-bit value between an even/odd pair of general registers and memory, using a single 32-bit memory port. A start strobe carries the direction (load or store), a base value, a signed 16-bit displacement and the index of the even register. The block forms a word-aligned effective address from the base and the displacement. It then issues two word accesses, one after the other, and each access waits for the memory to signal ready.

The word order is fixed. The odd register (index+1) is paired with the effective address, and the even register (the index given) is paired with the effective address plus four. On a load, each returned word is written through the register-file write port in the cycle its access completes. On a store, the words are taken from the two register-file read outputs. An odd index cannot name a pair, so it is refused with a one-cycle error strobe and no access is made. The done strobe follows the last access by one cycle, which gives consumers a cycle of separation before the loaded data is used. A base of zero makes the effective address the aligned, sign-extended displacement alone.

Top module: `dword_pair_seq`

## Requirements
- R1: The effective address is (base + sign-extended 16-bit offset) modulo 2^32 with bits [1:0] forced to zero; sign extension copies offset bit 15 into bits 31:16.
- R2: An accepted even-index command makes exactly two memory requests: first at the effective address, then at effective address + 4 (modulo 2^32). Each request holds its address, write flag and write data until a clock edge with mem_ready high. mem_we is 1 for a store (is_store=1) and 0 for a load.
- R3: On a load, the word returned for the first access is written to register index+1, and the word for the second access is written to register index. Each write happens in the same cycle as the completing access, and rf_we is never high at any other time.
- R4: On a store, the first access writes the contents of register index+1, and the second writes the contents of register index. rd_even_idx carries the index and rd_odd_idx carries index+1.
- R5: A command whose index has bit 0 set raises err_odd for exactly one cycle, in the cycle after it is accepted. That command makes no memory request, no register write and no done strobe.
- R6: done is high for exactly one cycle, in the cycle after the second access completes.
- R7: busy is high from the cycle after a command is accepted through its done or err_odd cycle, inclusive. A start seen while busy is high is ignored.
- R8: After reset, busy, done, err_odd, mem_req and rf_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when the unit is idle |
| is_store | input | 1 | 1 = store pair, 0 = load pair |
| base | input | 32 | Base value |
| offset | input | 16 | Signed displacement |
| reg_idx | input | 5 | Even register index of the pair |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| err_odd | output | 1 | One-cycle odd-index error strobe |
| rd_even_idx | output | 5 | Register-file read index, even register |
| rd_odd_idx | output | 5 | Register-file read index, odd register |
| rd_even_data | input | 32 | Contents of register rd_even_idx |
| rd_odd_data | input | 32 | Contents of register rd_odd_idx |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |

## Verification
Two events can meet in one cycle: a new start can arrive while the previous command finishes. This happens in the done cycle, in the err_odd cycle, or in the edge where the second access completes. To provoke this, the bench holds start high without a break through a whole run of commands and drives mem_ready from a pseudo-random pattern, so every such overlap occurs. A behavioural reference model in the bench decides, on each clock, whether the start was accepted. Every output is compared against that model, so a start that is wrongly taken shows up at once as a mismatch on busy or mem_req.

// File: rtl/dword_pair_seq.sv
module dword_pair_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_store,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  input  logic [RW-1:0] reg_idx,
  output logic          busy,
  output logic          done,
  output logic          err_odd,
  output logic [RW-1:0] rd_even_idx,
  output logic [RW-1:0] rd_odd_idx,
  input  logic [DW-1:0] rd_even_data,
  input  logic [DW-1:0] rd_odd_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);
  localparam logic [AW-1:0] AMASK = ~(WSTEP - AW'(1));

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_FIN, S_BAD} st_t;

  st_t           state;
  logic [AW-1:0] ea_q;
  logic [RW-1:0] idx_q;
  logic          st_q;

  logic [AW-1:0] ea_next;
  logic          accept, fire;

  assign ea_next = (base + {{(AW-OW){offset[OW-1]}}, offset}) & AMASK;
  assign accept  = (state == S_IDLE) && start;
  assign fire    = mem_req && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ea_q  <= '0;
      idx_q <= '0;
      st_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          ea_q  <= ea_next;
          idx_q <= reg_idx;
          st_q  <= is_store;
          state <= reg_idx[0] ? S_BAD : S_LO;
        end
        S_LO:    if (mem_ready) state <= S_HI;
        S_HI:    if (mem_ready) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = state != S_IDLE;
  assign done        = state == S_FIN;
  assign err_odd     = state == S_BAD;
  assign rd_even_idx = idx_q;
  assign rd_odd_idx  = idx_q | RW'(1);
  assign mem_req     = (state == S_LO) || (state == S_HI);
  assign mem_we      = mem_req && st_q;
  assign mem_addr    = (state == S_HI) ? ea_q + WSTEP : ea_q;
  assign mem_wdata   = (state == S_HI) ? rd_even_data : rd_odd_data;
  assign rf_we       = fire && !st_q;
  assign rf_widx     = (state == S_HI) ? rd_even_idx : rd_odd_idx;
  assign rf_wdata    = mem_rdata;

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & ~AMASK) == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_second_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !$past(mem_req)) |=> (mem_req && mem_addr == $past(mem_addr) + WSTEP));

  assert_write_only_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we));

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_odd |-> (!mem_req && !rf_we && !done && busy));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fire));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/sim_dword_pair_seq.sv
module sim_dword_pair_seq;
  localparam int NOPS = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_store = 1'b0, mem_ready = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [4:0]  reg_idx = '0;
  logic        busy, done, err_odd, rf_we, mem_req, mem_we;
  logic [4:0]  rd_even_idx, rd_odd_idx, rf_widx;
  logic [31:0] rd_even_data, rd_odd_data, rf_wdata, mem_addr, mem_wdata, mem_rdata;

  logic [31:0] regs [32];
  logic [31:0] op_base [NOPS];
  logic [15:0] op_off [NOPS];
  logic [4:0]  op_idx [NOPS];
  logic        op_st [NOPS];

  int checks = 0, errors = 0, cyc = 0, opi = 0;
  int phase = 0;
  logic [31:0] m_ea;
  logic [4:0]  m_idx;
  logic        m_st;
  logic [15:0] lfsr = 16'hACE1;
  logic        ready_always = 1'b0, start_always = 1'b0;

  always #2 clk = ~clk;

  dword_pair_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .base(base),
    .offset(offset), .reg_idx(reg_idx), .busy(busy), .done(done), .err_odd(err_odd),
    .rd_even_idx(rd_even_idx), .rd_odd_idx(rd_odd_idx), .rd_even_data(rd_even_data),
    .rd_odd_data(rd_odd_data), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  assign rd_even_data = regs[rd_even_idx];
  assign rd_odd_data  = regs[rd_odd_idx];
  assign mem_rdata    = {mem_addr[15:0] ^ 16'h3C5A, ~mem_addr[31:16]};

  function automatic logic [31:0] calc_ea(input logic [31:0] b, input logic [15:0] o);
    longint s;
    s = longint'(b) + longint'($signed(o));
    return 32'(s) & 32'hFFFF_FFFC;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // reference model state advance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) phase <= 0;
    else begin
      case (phase)
        0: if (start) begin
          m_ea <= calc_ea(base, offset);
          m_idx <= reg_idx;
          m_st <= is_store;
          phase <= reg_idx[0] ? 4 : 1;
          opi <= opi + 1;
        end
        1: if (mem_ready) begin
          if (!m_st) regs[m_idx + 5'd1] <= mem_rdata;
          phase <= 2;
        end
        2: if (mem_ready) begin
          if (!m_st) regs[m_idx] <= mem_rdata;
          phase <= 3;
        end
        default: phase <= 0;
      endcase
    end
  end

  // drive at falling edge, compare one ns later
  always @(negedge clk) begin
    int k;
    k = (opi < NOPS) ? opi : NOPS - 1;
    mem_ready <= ready_always | lfsr[0] | lfsr[4];
    start     <= rst_n && (opi < NOPS) && (start_always | lfsr[7] | lfsr[2]);
    base      <= op_base[k];
    offset    <= op_off[k];
    reg_idx   <= op_idx[k];
    is_store  <= op_st[k];
    #1;
    if (!rst_n) begin
      check("R8 busy in reset", 32'(busy), 0);
      check("R8 mem_req in reset", 32'(mem_req), 0);
      check("R8 done/err/rf_we in reset", {29'd0, done, err_odd, rf_we}, 0);
    end else begin
      check("R7 busy", 32'(busy), 32'(phase != 0));
      check("R6 done", 32'(done), 32'(phase == 3));
      check("R5 err_odd", 32'(err_odd), 32'(phase == 4));
      check("R2 mem_req", 32'(mem_req), 32'(phase == 1 || phase == 2));
      check("R3 rf_we", 32'(rf_we), 32'((phase == 1 || phase == 2) && !m_st && mem_ready));
      if (phase == 1 || phase == 2) begin
        check("R1 R2 mem_addr", mem_addr, (phase == 1) ? m_ea : m_ea + 32'd4);
        check("R2 mem_we", 32'(mem_we), 32'(m_st));
        check("R4 read indices", {22'd0, rd_even_idx, rd_odd_idx}, {22'd0, m_idx, m_idx + 5'd1});
        if (m_st)
          check("R4 mem_wdata", mem_wdata, (phase == 1) ? regs[m_idx + 5'd1] : regs[m_idx]);
        if (!m_st && mem_ready) begin
          check("R3 rf_widx", 32'(rf_widx), 32'((phase == 1) ? m_idx + 5'd1 : m_idx));
          check("R3 rf_wdata", rf_wdata, {mem_addr[15:0] ^ 16'h3C5A, ~mem_addr[31:16]});
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'h0101_0101 * i ^ 32'h5A00_00A5;
    for (int i = 0; i < NOPS; i++) begin
      op_base[i] = 32'h1357_9BDF * i + 32'h0000_0103;
      op_off[i]  = i[0] ? 16'hFFF0 - 16'(i) : 16'h0024 + 16'(i);
      op_idx[i]  = (i % 5 == 3) ? 5'(2 * i + 1) : 5'(2 * i);
      op_st[i]   = i[1];
    end
    // R1 corner: zero base, negative offset, wrap of address + 4
    op_base[0] = 32'h0; op_off[0] = 16'hFFFC; op_idx[0] = 5'd30; op_st[0] = 1'b0;
    op_base[1] = 32'h0; op_off[1] = 16'h0008; op_idx[1] = 5'd30; op_st[1] = 1'b1;
    op_base[2] = 32'h0000_0007; op_off[2] = 16'h7FFF; op_idx[2] = 5'd0; op_st[2] = 1'b1;
    op_base[3] = 32'h8000_0001; op_off[3] = 16'h8000; op_idx[3] = 5'd31; op_st[3] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait (opi >= 16);
    ready_always = 1'b1;
    wait (opi >= 24);
    ready_always = 1'b0;
    start_always = 1'b1;   // R7: start held across done/err cycles
    wait (opi >= 36);
    ready_always = 1'b1;
    wait (opi >= NOPS);
    repeat (8) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule